// File: doc/BRIEF.md
# Redundant SAR Conversion Sequencer

This block is the bit-cycling controller of a differential successive-approximation converter whose capacitor arrays are sampled on their top plates and switched monotonically. A start pulse opens a sampling window. The comparator is then clocked through a chain of decisions without any capacitor group switched first. After each decision one capacitor group on the side the comparator named is pulled from the reference to ground. There are eleven groups per side and twelve decisions, and the decisions carry non-binary effective weights of 480, 256, 128, 72, 40, 20, 12, 6, 4, 2, 2 and 1. The raw decisions leave the block unconverted, and a downstream adder turns them into binary.

Each decision waits for the comparator's own completion flag. If the flag never comes, a timeout forces a decision. A skip mode drops the last decision and gives the saved time to a longer sampling window.

Top module: `sar_redundant_seq`

## Requirements
- R1: A start pulse accepted while idle opens sampling. The sample enable is high for SAMP_NORM cycles (4) in normal mode and for SAMP_SKIP cycles (6) in skip mode, and the first comparator evaluation follows directly.
- R2: The cycle after a start is accepted, every group control on both banks reads 1 (bottom plate on reference; 0 means ground), and the raw code reads all zeros.
- R3: After each decision other than the final one, exactly one group control goes from 1 to 0. Decision k (k = 0 first) moves group k. It moves on the positive bank when the decision is 1 and on the negative bank when it is 0. No control returns to 1 before the next start.
- R4: Decision k is stored in code bit 11-k, so the first decision lands in the MSB. The first evaluation is made with all groups still on reference.
- R5: In skip mode a conversion makes 11 decisions, code bit 0 stays 0, and group 10 stays at 1 on both banks.
- R6: The comparator clock is low only while a decision is being evaluated. It is high in idle and during sampling, and it is high for exactly one cycle between two evaluations.
- R7: A decision is taken, with the value of the decision input, in the first cycle the ready input is high while the comparator clock is low.
- R8: If ready stays low for TIMEOUT (8) evaluation cycles, the decision is forced to 0 and the sequence advances.
- R9: The done output pulses for one cycle in the cycle after the final decision is taken. The code output holds its value until the next start.
- R10: A start pulse during a conversion is ignored.
- R11: The skip input is captured when a start is accepted. Changes to it during a conversion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request pulse |
| skip_sel_i | input | 1 | Omit final decision, lengthen sampling |
| cmp_rdy_i | input | 1 | Comparator has resolved |
| cmp_dec_i | input | 1 | Comparator result, 1 = positive side higher |
| samp_en_o | output | 1 | Sampling switch enable |
| cmp_clk_o | output | 1 | Comparator clock; high resets, low evaluates |
| dac_p_o | output | 11 | Positive bank group controls, 1 = reference |
| dac_n_o | output | 11 | Negative bank group controls, 1 = reference |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| code_o | output | 12 | Raw decision vector, MSB first |

## Verification
The hardest case to reach is the timeout path, because a correct comparator always answers. The bench models the comparator as a residue tracker driven from the bank outputs, and its answer latency is programmable. Setting that latency beyond the timeout starves every evaluation, so each decision is forced and the whole negative bank collapses in order. Skip mode is driven together with input toggles and stray start pulses in the middle of a conversion, which shows that the captured mode and the busy state protect the sequence.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_ARM  = 2'd2,
    ST_EVAL = 2'd3
  } seq_st_e;
endpackage

// File: rtl/sar_seq_cnt.sv
module sar_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sar_seq_bank.sv
module sar_seq_bank #(
  parameter int N_GRP = 11,
  parameter int GW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [GW-1:0]    idx_i,
  output logic [N_GRP-1:0] bank_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            bank_o[g] <= 1'b1;
      else if (clr_i)                         bank_o[g] <= 1'b1;
      else if (hit_i && (idx_i == GW'(g)))    bank_o[g] <= 1'b0;
    end
  end

  AST_BANK_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((bank_o & ~$past(bank_o)) == '0)); // R3
  AST_BANK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(bank_o ^ $past(bank_o)) <= 1)); // R3
endmodule

// File: rtl/sar_redundant_seq.sv
module sar_redundant_seq
  import sar_seq_pkg::*;
#(
  parameter int N_DEC     = 12,
  parameter int SAMP_NORM = 4,
  parameter int SAMP_SKIP = 6,
  parameter int TIMEOUT   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              skip_sel_i,
  input  logic              cmp_rdy_i,
  input  logic              cmp_dec_i,
  output logic              samp_en_o,
  output logic              cmp_clk_o,
  output logic [N_DEC-2:0]  dac_p_o,
  output logic [N_DEC-2:0]  dac_n_o,
  output logic              done_o,
  output logic [N_DEC-1:0]  code_o
);
  localparam int N_GRP  = N_DEC - 1;
  localparam int IDXW   = $clog2(N_DEC);
  localparam int GW     = $clog2(N_GRP);
  localparam int SMAX   = (SAMP_SKIP > SAMP_NORM) ? SAMP_SKIP : SAMP_NORM;
  localparam int SCW    = $clog2(SMAX + 1);
  localparam int TCW    = $clog2(TIMEOUT + 1);

  seq_st_e          st_q, st_d;
  logic [IDXW-1:0]  idx_q, last_idx;
  logic             skip_q, done_q;
  logic [N_DEC-1:0] code_q;
  logic [SCW-1:0]   samp_cnt, samp_last;
  logic [TCW-1:0]   wait_cnt;
  logic             accept, resolve, dec, is_last, hit_p, hit_n;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign samp_last = skip_q ? SCW'(SAMP_SKIP - 1) : SCW'(SAMP_NORM - 1);
  assign last_idx  = skip_q ? IDXW'(N_DEC - 2) : IDXW'(N_DEC - 1);
  assign is_last   = (idx_q == last_idx);
  assign resolve   = (st_q == ST_EVAL) && (cmp_rdy_i || (wait_cnt == TCW'(TIMEOUT - 1)));
  assign dec       = cmp_rdy_i & cmp_dec_i;   // timeout forces 0
  assign hit_p     = resolve && !is_last && dec;
  assign hit_n     = resolve && !is_last && !dec;

  sar_seq_cnt #(.W(SCW)) u_samp_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept),
    .en_i(st_q == ST_SAMP), .cnt_o(samp_cnt));

  sar_seq_cnt #(.W(TCW)) u_wait_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q != ST_EVAL),
    .en_i(1'b1), .cnt_o(wait_cnt));

  sar_seq_bank #(.N_GRP(N_GRP), .GW(GW)) u_bank_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept),
    .hit_i(hit_p), .idx_i(GW'(idx_q)), .bank_o(dac_p_o));

  sar_seq_bank #(.N_GRP(N_GRP), .GW(GW)) u_bank_n (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept),
    .hit_i(hit_n), .idx_i(GW'(idx_q)), .bank_o(dac_n_o));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_SAMP;
      ST_SAMP: if (samp_cnt == samp_last) st_d = ST_EVAL;
      ST_ARM:  st_d = ST_EVAL;
      ST_EVAL: if (resolve) st_d = is_last ? ST_IDLE : ST_ARM;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      skip_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= resolve && is_last;
      if (accept) begin
        idx_q  <= '0;
        skip_q <= skip_sel_i;
        code_q <= '0;
      end else if (resolve) begin
        code_q[IDXW'(N_DEC - 1) - idx_q] <= dec;
        if (!is_last) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign samp_en_o = (st_q == ST_SAMP);
  assign cmp_clk_o = (st_q != ST_EVAL);
  assign done_o    = done_q;
  assign code_o    = code_q;

  AST_CLK_HI_SAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_en_o |-> cmp_clk_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((&dac_p_o) && (&dac_n_o) && (code_o == '0))); // R2
  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EVAL) |=> ($stable(dac_p_o) || $stable(dac_n_o))); // R3
  AST_ARM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARM) |=> !cmp_clk_o); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EVAL && !resolve) |=> $stable(code_o)); // R7
endmodule

// File: tb/sar_redundant_seq_bench.sv
module sar_redundant_seq_bench;
  localparam int ND = 12, NG = 11, SN = 4, SS = 6, TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, skip_sel = 0, rdy = 0, dec = 0;
  logic samp_en, cmp_clk, done;
  logic [NG-1:0] dac_p, dac_n;
  logic [ND-1:0] code;

  int checks = 0, fails = 0;
  int vin_r = 0, lat_r = 1, lat_cnt = 0;
  int n_samp = 0, n_dec = 0;
  logic prev_clk = 1'b1;

  always #10 clk = ~clk;

  sar_redundant_seq u_sar_redundant_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .skip_sel_i(skip_sel),
    .cmp_rdy_i(rdy), .cmp_dec_i(dec), .samp_en_o(samp_en), .cmp_clk_o(cmp_clk),
    .dac_p_o(dac_p), .dac_n_o(dac_n), .done_o(done), .code_o(code));

  // behavioural reference
  int m_ph = 0, m_cnt = 0, m_w = 0, m_idx = 0;
  logic m_skip = 0, m_done = 0;
  logic [NG-1:0] m_p = '1, m_n = '1;
  logic [ND-1:0] m_code = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_w <= 0; m_idx <= 0; m_skip <= 0;
      m_done <= 0; m_p <= '1; m_n <= '1; m_code <= '0;
    end else begin
      m_done <= 0;
      case (m_ph)
        0: if (start) begin
             m_ph <= 1; m_cnt <= 0; m_skip <= skip_sel; m_idx <= 0;
             m_p <= '1; m_n <= '1; m_code <= '0;
           end
        1: if (m_cnt == (m_skip ? SS : SN) - 1) begin m_ph <= 3; m_w <= 0; end
           else m_cnt <= m_cnt + 1;
        2: begin m_ph <= 3; m_w <= 0; end
        default: if (rdy || m_w == TMO - 1) begin
             automatic logic d = rdy && dec;
             m_code[ND-1-m_idx] <= d;
             if (m_idx == (m_skip ? ND - 2 : ND - 1)) begin m_ph <= 0; m_done <= 1; end
             else begin
               if (d) m_p[m_idx] <= 1'b0; else m_n[m_idx] <= 1'b0;
               m_idx <= m_idx + 1; m_ph <= 2;
             end
           end else m_w <= m_w + 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int gw(input int g);
    case (g)
      0: return 256; 1: return 128; 2: return 72; 3: return 40; 4: return 20;
      5: return 12;  6: return 6;   7: return 4;  8: return 2;  9: return 2;
      default: return 1;
    endcase
  endfunction

  // per-clock compare, comparator model, event counters
  always @(negedge clk) begin
    if (rst_n) begin
      chk(samp_en == (m_ph == 1), "R1", "samp_en", samp_en, m_ph == 1);
      chk(cmp_clk == (m_ph != 3), "R6", "cmp_clk", cmp_clk, m_ph != 3);
      chk(dac_p == m_p, "R3", "dac_p", dac_p, m_p);
      chk(dac_n == m_n, "R3", "dac_n", dac_n, m_n);
      chk(done == m_done, "R9", "done", done, m_done);
      chk(code == m_code, "R4", "code", code, m_code);
      if (samp_en) n_samp++;
      if (prev_clk && !cmp_clk) n_dec++;
      prev_clk = cmp_clk;
      if (!cmp_clk) begin
        automatic int diff = vin_r;
        for (int g = 0; g < NG; g++) begin
          if (!dac_p[g]) diff -= gw(g);
          if (!dac_n[g]) diff += gw(g);
        end
        lat_cnt++;
        if (lat_cnt >= lat_r) begin rdy = 1; dec = (diff > 0); end
      end else begin
        lat_cnt = 0; rdy = 0; dec = 0;
      end
    end
  end

  task automatic conv(input int vin, input int lat, input bit skp,
                      input bit stray_start, input bit flip_skip);
    @(negedge clk);
    vin_r = vin; lat_r = lat; skip_sel = skp; start = 1;
    n_samp = 0; n_dec = 0;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 1000 && !done; c++) begin
      @(negedge clk);
      start = stray_start && (c == 9);
      if (flip_skip && c == 3) skip_sel = ~skp;
    end
    start = 0;
    chk(done, "R9", "done seen", done, 1);
    chk(n_samp == (skp ? SS : SN), "R1", "sample cycles", n_samp, skp ? SS : SN);
    chk(n_dec == (skp ? ND - 1 : ND), "R5", "decisions", n_dec, skp ? ND - 1 : ND);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!samp_en && cmp_clk && !done, "R6", "reset outputs", {samp_en, cmp_clk, done}, 3'b010);
    chk(dac_p == '1 && dac_n == '1, "R2", "reset banks", {dac_p, dac_n}, '1);
    chk(code == '0, "R4", "reset code", code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    conv(1000, 1, 0, 0, 0);   // all ones: R4, R3
    chk(code == 12'hFFF, "R4", "code high input", code, 12'hFFF);
    chk(dac_p == '0 && dac_n == '1, "R3", "p bank drained", dac_p, 0);
    repeat (3) @(negedge clk);
    chk(code == 12'hFFF && !done, "R9", "code hold", code, 12'hFFF);

    conv(-1000, 2, 0, 0, 0);
    chk(code == 12'h000 && dac_n == '0, "R4", "code low input", code, 0);

    conv(300, 3, 0, 0, 0);    // mixed decisions, R7 latency
    conv(-77, 1, 0, 0, 0);

    conv(555, 2, 1, 0, 0);    // skip mode R5
    chk(code[0] == 1'b0, "R5", "skip lsb", code[0], 0);
    chk(dac_p[NG-1] && dac_n[NG-1], "R5", "skip last group", {dac_p[NG-1], dac_n[NG-1]}, 2'b11);

    conv(123, 50, 0, 0, 0);   // timeout R8
    chk(code == '0, "R8", "timeout code", code, 0);
    chk(dac_n == '0 && dac_p == '1, "R8", "timeout banks", {dac_p, dac_n}, {11'h7FF, 11'h0});

    conv(200, 2, 0, 1, 0);    // stray start R10
    conv(-400, 1, 0, 0, 1);   // skip flip mid conversion R11
    conv(90, 2, 1, 0, 1);     // skip held despite flip R11

    @(negedge clk);
    start = 1;                 // start in done cycle region / idle R2
    @(negedge clk);
    start = 0;
    chk(dac_p == '1 && dac_n == '1 && code == '0, "R2", "start clears", {dac_p, dac_n}, '1);
    for (int c = 0; c < 1000 && !done; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule